// File: doc/BRIEF.md
# Audio Master Clock Table Divider

This block turns one audio PLL clock into two independent master-clock enable streams, one for the transmit path and one for the receive path. Each stream is a single-cycle enable pulse that repeats every N cycles of the PLL clock. N comes from a fixed, non-linear ratio table and is chosen by a 3-bit index per channel. One index code is reserved and switches its channel off.

A single 32-bit configuration word is written through a simple write strobe and is always visible on a read-back port. Besides the two ratio indices and two active-low gate bits, the word holds control bits for the analog PLL: power, enable, reset, a family-select bit and a 6-bit validity key. The block stores these bits as written. It derives a "PLL valid" status from them and reports the family-select bit to the PLL model. No output pulse is produced while the PLL is not valid.

A new ratio index is picked up only when its channel's counter wraps. A period that is already in progress always finishes at its old length, so no runt period is produced.

Top module: `audio_mclk_div`

## Requirements
- R1: `cfg_rdata` shows the word last written with `cfg_we`=1, starting in the cycle after the write edge; all 32 bits are stored.
- R2: `pll_valid` is 1 only when bit 11 (PLL reset) is 0, bit 0 (power) is 1, bit 3 (enable) is 1 and bits 9:4 equal 0x12; the value 0x129 is the smallest valid word.
- R3: `rate_family` equals bit 1 of the stored word (1 = 44.1 kHz family, 0 = 48 kHz family).
- R4: The transmit index sits in bits 18:16 and the receive index in bits 26:24. Index codes 0,1,2,3,4,5,6 give pulse spacings of 3,6,9,12,18,24,32 cycles, and each pulse is one cycle wide.
- R5: Index code 7 holds that channel's output at 0.
- R6: Bit 19 set to 1 stops the transmit pulses and bit 27 set to 1 stops the receive pulses; 0 lets them run. Gating one channel does not affect the other.
- R7: While `pll_valid` is 0, both outputs stay 0 from the following cycle on.
- R8: An index change takes effect only at the channel's next wrap. The period running when the change is written completes with the old spacing, and the spacing after that uses the new one.
- R9: When a channel starts from the stopped state, its first pulse is visible in the second cycle after the enabling write edge: the register takes one edge and the pulse register one more.
- R10: After reset the stored word is 0, `pll_valid` and `rate_family` are 0, and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio PLL clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word to store |
| cfg_rdata | output | 32 | Stored configuration word |
| pll_valid | output | 1 | PLL control fields form a valid setting |
| rate_family | output | 1 | PLL rate family select to the PLL model |
| tx_mck_en | output | 1 | Transmit master clock enable pulse |
| rx_mck_en | output | 1 | Receive master clock enable pulse |

## Verification
The bench measures the spacing of every table entry, including the odd ratios 3 and 9 and the longest ratio 32. A table wired in the wrong order, or a counter that reloads at N instead of N-1, shows up as a wrong gap. It writes the reserved index, each gate bit, and validity keys broken one field at a time. A decoder that ignores the key, the reset bit or the gate polarity would keep pulsing. It changes an index in the middle of a long period. A design that reloads at once would cut that period short. A random phase compares every cycle against a model built from the requirements.

// File: rtl/audmck_pkg.sv
package audmck_pkg;

    localparam int CFG_W       = 32;
    localparam int IDX_W       = 3;
    localparam int RATIO_W     = 6;
    localparam int NUM_CH      = 2;

    // PLL control field positions
    localparam int PWR_BIT     = 0;
    localparam int FAM_BIT     = 1;
    localparam int ENA_BIT     = 3;
    localparam int KEY_LSB     = 4;
    localparam int KEY_W       = 6;
    localparam logic [KEY_W-1:0] KEY_VAL = 6'h12;
    localparam int PRST_BIT    = 11;

    // channel field positions: 0 = transmit, 1 = receive
    localparam int TX_IDX_LSB  = 16;
    localparam int TX_GATE_BIT = 19;
    localparam int RX_IDX_LSB  = 24;
    localparam int RX_GATE_BIT = 27;

    localparam logic [IDX_W-1:0] OFF_IDX = 3'd7;

    function automatic int idx_lsb(input int ch);
        return (ch == 0) ? TX_IDX_LSB : RX_IDX_LSB;
    endfunction

    function automatic int gate_bit(input int ch);
        return (ch == 0) ? TX_GATE_BIT : RX_GATE_BIT;
    endfunction

    // divide ratio table, reserved code yields 0
    function automatic logic [RATIO_W-1:0] ratio_of(input logic [IDX_W-1:0] i);
        logic [RATIO_W-1:0] r;
        case (i)
            3'd0:    r = 6'd3;
            3'd1:    r = 6'd6;
            3'd2:    r = 6'd9;
            3'd3:    r = 6'd12;
            3'd4:    r = 6'd18;
            3'd5:    r = 6'd24;
            3'd6:    r = 6'd32;
            default: r = 6'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/audmck_cfg.sv
module audmck_cfg
    import audmck_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [CFG_W-1:0]              wdata,
    output logic [CFG_W-1:0]              cfg,
    output logic                          valid,
    output logic                          family,
    output logic [NUM_CH-1:0]             ch_run,
    output logic [NUM_CH-1:0][IDX_W-1:0]  ch_idx
);

    typedef struct packed {
        logic [CFG_W-1:0] word;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.word = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg    = st_q.word;
    assign family = st_q.word[FAM_BIT];
    assign valid  = !st_q.word[PRST_BIT]
                  && st_q.word[PWR_BIT]
                  && st_q.word[ENA_BIT]
                  && (st_q.word[KEY_LSB +: KEY_W] == KEY_VAL);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dec
        localparam int LSB = idx_lsb(ch);
        localparam int GB  = gate_bit(ch);
        assign ch_idx[ch] = st_q.word[LSB +: IDX_W];
        assign ch_run[ch] = valid && !st_q.word[GB];
    end

endmodule

// File: rtl/audmck_chan.sv
module audmck_chan
    import audmck_pkg::*;
#(
    parameter int CNT_W = RATIO_W
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [IDX_W-1:0] idx,
    output logic             mck_en
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic [RATIO_W-1:0] ratio;

    assign ratio = ratio_of(idx);

    always_comb begin
        st_d = st_q;
        st_d.pulse = 1'b0;
        if (!run) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == '0) begin
            // wrap point: the index is sampled here only
            if (idx == OFF_IDX) begin
                st_d.cnt = '0;
            end else begin
                st_d.pulse = 1'b1;
                st_d.cnt   = CNT_W'(ratio - RATIO_W'(1));
            end
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mck_en = st_q.pulse;

endmodule

// File: rtl/audio_mclk_div.sv
module audio_mclk_div
    import audmck_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        pll_valid,
    output logic        rate_family,
    output logic        tx_mck_en,
    output logic        rx_mck_en
);

    logic [NUM_CH-1:0]            ch_run;
    logic [NUM_CH-1:0][IDX_W-1:0] ch_idx;
    logic [NUM_CH-1:0]            ch_en;

    audmck_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .cfg    (cfg_rdata),
        .valid  (pll_valid),
        .family (rate_family),
        .ch_run (ch_run),
        .ch_idx (ch_idx)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        audmck_chan #(.CNT_W(RATIO_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (ch_run[ch]),
            .idx    (ch_idx[ch]),
            .mck_en (ch_en[ch])
        );
    end

    assign tx_mck_en = ch_en[0];
    assign rx_mck_en = ch_en[1];

endmodule

// File: rtl/audmck_chk.sv
module audmck_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        pll_valid,
    input logic        tx_mck_en,
    input logic        rx_mck_en
);

    // R1
    wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == $past(cfg_wdata)));

    // R7
    invalid_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_valid |=> (!tx_mck_en && !rx_mck_en));

    // R6
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[19] |=> !tx_mck_en);

    // R6
    rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[27] |=> !rx_mck_en);

    // R5
    tx_off_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[18:16] == 3'd7) |=> !tx_mck_en);

    // R5
    rx_off_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[26:24] == 3'd7) |=> !rx_mck_en);

    // R4
    tx_min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_mck_en |-> ##1 !tx_mck_en ##1 !tx_mck_en);

    // R4
    rx_min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_mck_en |-> ##1 !rx_mck_en ##1 !rx_mck_en);

endmodule

bind audio_mclk_div audmck_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .pll_valid (pll_valid),
    .tx_mck_en (tx_mck_en),
    .rx_mck_en (rx_mck_en)
);

// File: tb/audio_mclk_div_tb.sv
`timescale 1ns/1ps
module audio_mclk_div_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        pll_valid, rate_family, tx_mck_en, rx_mck_en;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;
    bit model_on = 0;

    always #4 clk = ~clk;

    audio_mclk_div u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .pll_valid(pll_valid), .rate_family(rate_family),
        .tx_mck_en(tx_mck_en), .rx_mck_en(rx_mck_en)
    );

    localparam logic [31:0] BASE = 32'h0000_0129;

    function automatic int spacing(input logic [2:0] i);
        int t[7] = '{3, 6, 9, 12, 18, 24, 32};
        return (i == 3'd7) ? 0 : t[i];
    endfunction

    function automatic bit exp_valid(input logic [31:0] w);
        return (w[11] == 1'b0) && w[0] && w[3] && (w[9:4] == 6'h12);
    endfunction

    function automatic logic [31:0] mk(input logic [2:0] ti, input logic [2:0] ri,
                                       input bit tg, input bit rg, input bit fam);
        logic [31:0] w = BASE;
        w[18:16] = ti; w[26:24] = ri; w[19] = tg; w[27] = rg; w[1] = fam;
        return w;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model, built from the requirements
    logic [31:0] m_cfg;
    int          m_cnt[2];
    bit          m_p[2];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cfg <= '0;
            for (int c = 0; c < 2; c++) begin m_cnt[c] <= 0; m_p[c] <= 0; end
        end else begin
            for (int c = 0; c < 2; c++) begin
                logic [2:0] ix;
                bit run;
                ix  = (c == 0) ? m_cfg[18:16] : m_cfg[26:24];
                run = exp_valid(m_cfg) && !((c == 0) ? m_cfg[19] : m_cfg[27]);
                if (!run) begin m_cnt[c] <= 0; m_p[c] <= 0; end
                else if (m_cnt[c] == 0) begin
                    if (ix == 3'd7) begin m_p[c] <= 0; m_cnt[c] <= 0; end
                    else begin m_p[c] <= 1; m_cnt[c] <= spacing(ix) - 1; end
                end else begin m_cnt[c] <= m_cnt[c] - 1; m_p[c] <= 0; end
            end
            if (cfg_we) m_cfg <= cfg_wdata;
        end
    end

    always @(negedge clk) begin
        if (rst_n && model_on) begin
            chk("R1 readback", cfg_rdata, m_cfg);
            chk("R2 pll_valid", pll_valid, exp_valid(m_cfg));
            chk("R3 family", rate_family, m_cfg[1]);
            chk("R4/R8 tx pulse", tx_mck_en, m_p[0]);
            chk("R4/R8 rx pulse", rx_mck_en, m_p[1]);
        end
    end

    task automatic wr(input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic bit sel(input int c);
        return (c == 0) ? tx_mck_en : rx_mck_en;
    endfunction

    // gap in cycles between two consecutive pulses of channel c
    task automatic gap(input int c, output int g);
        int lim = 0;
        g = 0;
        while (!sel(c) && lim < 200) begin @(negedge clk); lim++; end
        do begin @(negedge clk); g++; end while (!sel(c) && g < 200);
    endtask

    task automatic quiet(input int c, input int cycles, output int seen);
        seen = 0;
        repeat (cycles) begin @(negedge clk); if (sel(c)) seen++; end
    endtask

    initial begin
        int g, s;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R10 reset state
        chk("R10 rdata", cfg_rdata, 0);
        chk("R10 pll_valid", pll_valid, 0);
        chk("R10 tx", tx_mck_en, 0);
        chk("R10 rx", rx_mck_en, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 tx after release", tx_mck_en, 0);
        chk("R10 family", rate_family, 0);

        // R9 latency from stopped state
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = mk(3'd0, 3'd0, 0, 0, 0);
        @(negedge clk); cfg_we = 1'b0;
        chk("R9 no pulse yet", tx_mck_en, 0);
        chk("R1 readback directed", cfg_rdata, mk(3'd0, 3'd0, 0, 0, 0));
        chk("R2 valid for 0x129", pll_valid, 1);
        @(negedge clk);
        chk("R9 first tx pulse", tx_mck_en, 1);
        chk("R9 first rx pulse", rx_mck_en, 1);
        @(negedge clk);
        chk("R4 pulse one cycle wide", tx_mck_en, 0);

        // R4 every table entry on both channels
        for (int i = 0; i < 7; i++) begin
            wr(mk(3'(i), 3'(6 - i), 0, 0, 0));
            gap(0, g); gap(0, g);
            chk($sformatf("R4 tx idx %0d", i), g, spacing(3'(i)));
            gap(1, g); gap(1, g);
            chk($sformatf("R4 rx idx %0d", 6 - i), g, spacing(3'(6 - i)));
        end

        // R5 reserved index
        wr(mk(3'd7, 3'd0, 0, 0, 0));
        repeat (35) @(negedge clk);
        quiet(0, 100, s); chk("R5 tx idx7 silent", s, 0);
        gap(1, g); chk("R5 rx unaffected", g, 3);
        wr(mk(3'd1, 3'd7, 0, 0, 0));
        repeat (35) @(negedge clk);
        quiet(1, 100, s); chk("R5 rx idx7 silent", s, 0);

        // R6 gates
        wr(mk(3'd0, 3'd0, 1, 0, 0));
        quiet(0, 60, s); chk("R6 tx gated", s, 0);
        gap(1, g); chk("R6 rx still runs", g, 3);
        wr(mk(3'd0, 3'd0, 0, 1, 0));
        quiet(1, 60, s); chk("R6 rx gated", s, 0);
        gap(0, g); chk("R6 tx runs with bit19=0", g, 3);

        // R2 / R7 broken keys
        wr(BASE | 32'h0000_0800);
        quiet(0, 40, s); chk("R7 reset bit set tx", s, 0);
        chk("R2 reset bit", pll_valid, 0);
        wr(BASE & ~32'h1);
        quiet(1, 40, s); chk("R7 power off rx", s, 0);
        chk("R2 power bit", pll_valid, 0);
        wr(BASE & ~32'h8);
        chk("R2 enable bit", pll_valid, 0);
        wr((BASE & ~32'h3F0) | 32'h130);
        quiet(0, 40, s); chk("R7 wrong key tx", s, 0);
        chk("R2 wrong key", pll_valid, 0);

        // R3 family
        wr(mk(3'd2, 3'd2, 0, 0, 1));
        chk("R3 family=1", rate_family, 1);
        wr(mk(3'd2, 3'd2, 0, 0, 0));
        chk("R3 family=0", rate_family, 0);

        // R8 index change mid period
        wr(mk(3'd6, 3'd6, 0, 0, 0));
        gap(0, g);
        while (!tx_mck_en) @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = mk(3'd0, 3'd6, 0, 0, 0);
        @(negedge clk); cfg_we = 1'b0;
        g = 1;
        while (!tx_mck_en && g < 200) begin @(negedge clk); g++; end
        chk("R8 old period completes", g, 32);
        gap(0, g);
        chk("R8 new ratio after wrap", g, 3);

        // random phase with cycle model
        model_on = 1;
        for (int k = 0; k < 300; k++) begin
            logic [31:0] w;
            if ($urandom_range(9) == 0) w = $urandom;
            else w = mk(3'($urandom_range(7)), 3'($urandom_range(7)),
                        $urandom_range(7) == 0, $urandom_range(7) == 0,
                        1'($urandom_range(1)));
            wr(w);
            repeat ($urandom_range(120, 1)) @(negedge clk);
        end
        model_on = 0;

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule